// File: doc/BRIEF.md
# Programming Access Key Gate

This block guards the internal bus that a byte-oriented programming link uses to reach the nonvolatile memory controller. After the link comes up or recovers from an error, the nonvolatile region is locked. The programmer opens it by sending a key command byte followed by eight key bytes. Together the eight bytes form a 64-bit unlock value. When all eight bytes match the built-in constant, a sticky unlock flag is set. When the sequence ends with any wrong byte, the flag is left as it was and a single-cycle mismatch pulse is raised.

Bus requests pass through the block. A request to an address below the nonvolatile base is always forwarded. A request to an address at or above the base is forwarded only while the block is unlocked. While locked, such a request is dropped and answered with zero data. Link reset, or entry into the link error state, closes the lock again and abandons any key sequence that is still being collected.

Top module: `kg_key_gate`

## Requirements
- R1: After reset, `unlocked_o`, `key_mismatch_o`, `fwd_req_o`, `rsp_valid_o` and `rsp_data_o` are all zero.
- R2: An accepted byte of value 0xE0 starts key collection. Collection consumes the next eight accepted bytes, least significant byte first: FF 88 D8 CD 45 AB 89 12 (the value 0x1289AB45CDD888FF). If all eight match, `unlocked_o` is high from the clock edge that accepts the eighth byte.
- R3: If any of the eight key bytes differs, `unlocked_o` is not set. `key_mismatch_o` is then high for exactly the one cycle that follows the edge accepting the eighth byte.
- R4: A failed sequence leaves no partial match behind. A fresh 0xE0 followed by the correct key then unlocks the block.
- R5: A byte is accepted only on an edge where `cmd_valid_i` is high. While no collection is running, accepted bytes other than 0xE0 have no effect.
- R6: Unlock is sticky. A later wrong key does not clear it, but it still pulses `key_mismatch_o`.
- R7: `link_reset_i` clears `unlocked_o` and aborts any collection in progress. It takes precedence over a byte accepted on the same edge.
- R8: While locked, a request with `req_addr_i` >= 0x800000 produces no `fwd_req_o`. One edge later its response has `rsp_valid_o` high and `rsp_data_o` equal to zero.
- R9: A request below 0x800000, or any request while unlocked, is forwarded one edge later on `fwd_req_o`/`fwd_addr_o`, with `rsp_data_o` equal to `bus_rdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Link byte strobe |
| cmd_byte_i | input | 8 | Link byte |
| link_reset_i | input | 1 | Link reset or error-state pulse |
| req_valid_i | input | 1 | Internal bus request strobe |
| req_addr_i | input | 24 | Request address |
| bus_rdata_i | input | 8 | Read data from internal bus for current request |
| unlocked_o | output | 1 | Sticky nonvolatile access enable |
| key_mismatch_o | output | 1 | One-cycle wrong-key pulse |
| fwd_req_o | output | 1 | Request forwarded to internal bus |
| fwd_addr_o | output | 24 | Forwarded address |
| rsp_valid_o | output | 1 | Response strobe back to link |
| rsp_data_o | output | 8 | Response data, zero when blocked |

## Verification
Every result of this block is due one clock edge after the stimulus that causes it. Unlock and mismatch follow the edge that accepts the eighth key byte. Forwarding and response data follow the edge that samples the request. The bench drives all inputs at the falling edge and waits through one rising edge. At the next falling edge it compares the outputs with a reference model, which has already been advanced by the same accepted inputs. Request gating is judged on the lock state the model held before that edge, so a request in the same cycle as the final key byte is still expected to be blocked.

// File: rtl/kg_pkg.sv
package kg_pkg;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_COLLECT = 1'b1} seq_state_e;
  localparam logic [63:0] KG_DEFAULT_KEY = 64'h1289AB45CDD888FF;
  localparam logic [7:0]  KG_DEFAULT_OP  = 8'hE0;
endpackage

// File: rtl/kg_key_seq.sv
module kg_key_seq
  import kg_pkg::*;
#(
  parameter int KEY_BYTES = 8,
  parameter logic [KEY_BYTES*8-1:0] KEY_VALUE = KG_DEFAULT_KEY,
  parameter logic [7:0] KEY_OP = KG_DEFAULT_OP
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  input  logic       link_rst_i,
  output logic       good_o,
  output logic       bad_o
);
  localparam int CW = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1;
  localparam logic [CW-1:0] LAST = CW'(KEY_BYTES - 1);

  logic [7:0] key_arr [KEY_BYTES];
  for (genvar g = 0; g < KEY_BYTES; g++) begin : g_key
    assign key_arr[g] = KEY_VALUE[g*8 +: 8];
  end

  seq_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic ok_q;
  logic hit, final_byte;

  assign hit        = (byte_i == key_arr[cnt_q]);
  assign final_byte = byte_valid_i && !link_rst_i && (state_q == SEQ_COLLECT) && (cnt_q == LAST);
  assign good_o     = final_byte && ok_q && hit;
  assign bad_o      = final_byte && !(ok_q && hit);

  always_ff @(posedge clk) begin
    if (rst || link_rst_i) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      ok_q    <= 1'b0;
    end else if (byte_valid_i) begin
      if (state_q == SEQ_IDLE) begin
        if (byte_i == KEY_OP) begin
          state_q <= SEQ_COLLECT;
          cnt_q   <= '0;
          ok_q    <= 1'b1;
        end
      end else if (cnt_q == LAST) begin
        state_q <= SEQ_IDLE;
        cnt_q   <= '0;
        ok_q    <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        ok_q  <= ok_q && hit;
      end
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  p_abort_r7: assert property (@(posedge clk) disable iff (rst)
    link_rst_i |=> (state_q == SEQ_IDLE) && !good_o);
endmodule

// File: rtl/kg_lock.sv
module kg_lock (
  input  logic clk,
  input  logic rst,
  input  logic link_rst_i,
  input  logic good_i,
  input  logic bad_i,
  output logic unlocked_o,
  output logic mismatch_o
);
  logic unlocked_q, mismatch_q;

  always_ff @(posedge clk) begin
    if (rst || link_rst_i) begin
      unlocked_q <= 1'b0;
      mismatch_q <= 1'b0;
    end else begin
      if (good_i) unlocked_q <= 1'b1;
      mismatch_q <= bad_i;
    end
  end

  assign unlocked_o = unlocked_q;
  assign mismatch_o = mismatch_q;

  p_unlock_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked_q) |-> $past(good_i));
  p_mismatch_single_r3: assert property (@(posedge clk) disable iff (rst)
    mismatch_q |=> !mismatch_q);
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    unlocked_q && !link_rst_i |=> unlocked_q);
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    link_rst_i |=> !unlocked_q && !mismatch_q);
endmodule

// File: rtl/kg_bus_gate.sv
module kg_bus_gate #(
  parameter int AW = 24,
  parameter int DW = 8,
  parameter logic [AW-1:0] NVM_BASE = 24'h800000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          unlocked_i,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          fwd_req_o,
  output logic [AW-1:0] fwd_addr_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o
);
  logic in_nvm, allow;
  assign in_nvm = (req_addr_i >= NVM_BASE);
  assign allow  = !in_nvm || unlocked_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_req_o   <= 1'b0;
      fwd_addr_o  <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      fwd_req_o   <= req_valid_i && allow;
      fwd_addr_o  <= (req_valid_i && allow) ? req_addr_i : '0;
      rsp_valid_o <= req_valid_i;
      rsp_data_o  <= (req_valid_i && allow) ? bus_rdata_i : '0;
    end
  end

  p_block_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid_i && in_nvm && !unlocked_i |=> !fwd_req_o && rsp_valid_o && (rsp_data_o == '0));
  p_pass_low_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid_i && !in_nvm |=> fwd_req_o);
endmodule

// File: rtl/kg_key_gate.sv
module kg_key_gate
  import kg_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 8,
  parameter int KEY_BYTES = 8,
  parameter logic [KEY_BYTES*8-1:0] KEY_VALUE = KG_DEFAULT_KEY,
  parameter logic [7:0] KEY_OP = KG_DEFAULT_OP,
  parameter logic [AW-1:0] NVM_BASE = 24'h800000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid_i,
  input  logic [7:0]    cmd_byte_i,
  input  logic          link_reset_i,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          unlocked_o,
  output logic          key_mismatch_o,
  output logic          fwd_req_o,
  output logic [AW-1:0] fwd_addr_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o
);
  logic good, bad;

  kg_key_seq #(.KEY_BYTES(KEY_BYTES), .KEY_VALUE(KEY_VALUE), .KEY_OP(KEY_OP)) u_seq (
    .clk(clk), .rst(rst), .byte_valid_i(cmd_valid_i), .byte_i(cmd_byte_i),
    .link_rst_i(link_reset_i), .good_o(good), .bad_o(bad));

  kg_lock u_lock (
    .clk(clk), .rst(rst), .link_rst_i(link_reset_i), .good_i(good), .bad_i(bad),
    .unlocked_o(unlocked_o), .mismatch_o(key_mismatch_o));

  kg_bus_gate #(.AW(AW), .DW(DW), .NVM_BASE(NVM_BASE)) u_gate (
    .clk(clk), .rst(rst), .unlocked_i(unlocked_o), .req_valid_i(req_valid_i),
    .req_addr_i(req_addr_i), .bus_rdata_i(bus_rdata_i), .fwd_req_o(fwd_req_o),
    .fwd_addr_o(fwd_addr_o), .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o));
endmodule

// File: tb/kg_key_gate_bench.sv
module kg_key_gate_bench;
  localparam logic [63:0] KEY = 64'h1289AB45CDD888FF;
  localparam logic [23:0] BASE = 24'h800000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid_i = 1'b0, link_reset_i = 1'b0, req_valid_i = 1'b0;
  logic [7:0] cmd_byte_i = '0, bus_rdata_i = '0;
  logic [23:0] req_addr_i = '0;
  logic unlocked_o, key_mismatch_o, fwd_req_o, rsp_valid_o;
  logic [23:0] fwd_addr_o;
  logic [7:0] rsp_data_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  bit m_unl = 0, m_col = 0, m_ok = 0, m_mis = 0;
  int m_cnt = 0;

  always #4 clk = ~clk;

  kg_key_gate u_kg_key_gate (.*);

  function automatic logic [7:0] key_byte(int i);
    return KEY[i*8 +: 8];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(bit v, logic [7:0] b, bit lr, bit rv, logic [23:0] a, logic [7:0] rd);
    bit allow;
    @(negedge clk);
    cmd_valid_i = v; cmd_byte_i = b; link_reset_i = lr;
    req_valid_i = rv; req_addr_i = a; bus_rdata_i = rd;
    allow = (a < BASE) || m_unl;
    if (lr) begin
      m_unl = 0; m_mis = 0; m_col = 0;
    end else begin
      m_mis = 0;
      if (v) begin
        if (!m_col) begin
          if (b == 8'hE0) begin m_col = 1; m_cnt = 0; m_ok = 1; end
        end else if (m_cnt == 7) begin
          if (m_ok && b == key_byte(7)) m_unl = 1; else m_mis = 1;
          m_col = 0;
        end else begin
          m_ok = m_ok && (b == key_byte(m_cnt));
          m_cnt++;
        end
      end
    end
    @(negedge clk);
    cmd_valid_i = 0; link_reset_i = 0; req_valid_i = 0;
    check("R2/R6/R7 unlocked", 32'(unlocked_o), 32'(m_unl));
    check("R3 mismatch", 32'(key_mismatch_o), 32'(m_mis));
    check("R8/R9 fwd_req", 32'(fwd_req_o), 32'(rv && allow));
    check("R8 rsp_valid", 32'(rsp_valid_o), 32'(rv));
    check("R8/R9 rsp_data", 32'(rsp_data_o), (rv && allow) ? 32'(rd) : 32'h0);
    if (rv && allow) check("R9 fwd_addr", 32'(fwd_addr_o), 32'(a));
  endtask

  task automatic send(logic [7:0] b);
    step(1, b, 0, 0, '0, '0);
  endtask

  task automatic send_key(int bad_idx);
    send(8'hE0);
    for (int i = 0; i < 8; i++) send(i == bad_idx ? key_byte(i) ^ 8'h01 : key_byte(i));
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd7);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 unlocked", 32'(unlocked_o), 0);
    check("R1 mismatch", 32'(key_mismatch_o), 0);
    check("R1 fwd", 32'(fwd_req_o), 0);
    check("R1 rsp", 32'({rsp_valid_o, rsp_data_o}), 0);
    // R8 locked high request blocked
    step(0, 0, 0, 1, 24'h800010, 8'hA5);
    // R9 low request passes while locked
    step(0, 0, 0, 1, 24'h000123, 8'h3C);
    // R5 junk while idle, invalid strobe
    send(8'hFF); send(8'h12);
    step(0, 8'hE0, 0, 0, '0, '0);
    send(8'hFF);
    check("R5 still locked", 32'(unlocked_o), 0);
    // R3 wrong key (last byte), then R4 correct key
    send_key(7);
    send_key(-1);
    check("R4 unlocked after retry", 32'(unlocked_o), 1);
    // R9 nvm request while unlocked
    step(0, 0, 0, 1, 24'hFFFFFF, 8'h5A);
    // R6 wrong key keeps unlock
    send_key(0);
    check("R6 still unlocked", 32'(unlocked_o), 1);
    // R7 link reset clears
    step(0, 0, 1, 0, '0, '0);
    check("R7 cleared", 32'(unlocked_o), 0);
    // R7 abort mid-key: reset after 4 bytes, then remaining bytes do nothing
    send(8'hE0);
    for (int i = 0; i < 4; i++) send(key_byte(i));
    step(0, 0, 1, 0, '0, '0);
    for (int i = 4; i < 8; i++) send(key_byte(i));
    check("R7 aborted stays locked", 32'(unlocked_o), 0);
    // R7 reset with final byte on same edge; R5 gaps inside key
    send(8'hE0);
    for (int i = 0; i < 7; i++) begin send(key_byte(i)); step(0, 8'h00, 0, 0, '0, '0); end
    step(1, key_byte(7), 1, 0, '0, '0);
    check("R7 precedence", 32'(unlocked_o), 0);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 8) send_key((($urandom_range(0, 3)) == 0) ? -1 : int'($urandom_range(0, 7)));
      else if (r < 10) step(0, 0, 1, 0, '0, '0);
      else step($urandom_range(0, 1), 8'($urandom), 0, $urandom_range(0, 1),
                24'($urandom), 8'($urandom));
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule